// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switching element of a two-dimensional mesh network on chip. It has five bidirectional flit ports: one toward each compass neighbour (north, south, east, west) and one toward the local cluster. Every flit is 34 bits wide: a 32-bit data word plus a begin-of-packet and an end-of-packet marker. The first flit of a packet carries the absolute column and row of the destination cluster. The router compares them with its own position, which is given on static inputs. Packets travel along the column axis first and then along the row axis, so each source and destination pair always takes the same path and arrives in order.

Each input keeps a two-entry flit buffer. When a header reaches the head of a buffer, it asks for the output chosen by the routing rule. Each output picks one of the competing headers by rotating priority. The winning input then owns that output until the end-of-packet flit of its packet has been taken by the downstream receiver, so packets are never interleaved on a link. All links use a valid/ready handshake, and a flit moves on a clock edge where both are high.

Top module: `mesh_router`

## Requirements
- R1: Flit bit 33 marks the start of a packet, bit 32 marks the end, and bits 31:0 are data. In a header, the destination column is in bits 7:4 and the destination row is in bits 3:0. Every flit leaves with all 34 bits unchanged.
- R2: A header whose destination column and row both equal the router's own coordinates leaves on port 0 (local).
- R3: A header whose destination column is greater than the router's column leaves on port 3 (east). If the destination column is smaller, it leaves on port 4 (west).
- R4: When the destination column equals the router's column, a greater destination row sends the header to port 1 (north) and a smaller row sends it to port 2 (south).
- R5: All flits of a packet leave on the output its header took, in order. No flit of another packet appears on that output until the end-of-packet flit has been accepted there.
- R6: When several headers want the same free output, the winner is the first requester found from the input just after the previous winner of that output, counting upward and wrapping from 4 to 0. After reset the search starts at input 0.
- R7: A packet that holds an output keeps it even if a higher-priority header arrives. The rotating priority moves only when a new packet is granted.
- R8: A flit transfers on a clock edge where valid and ready are both high. An output that shows valid with ready low keeps valid high and the flit unchanged on the next cycle.
- R9: Each input accepts at most two flits that have not yet left. While two are held, its ready output is low.
- R10: During and right after reset, every output valid is low and every input ready is high.
- R11: An output is released in the cycle its end-of-packet flit is accepted. A header already waiting for that output appears on it in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| myX | input | 4 | Router column, static |
| myY | input | 4 | Router row, static |
| inValid | input | 5 | Flit valid per input port (0 local, 1 north, 2 south, 3 east, 4 west) |
| inFlit | input | 5x34 | Flit per input port |
| inReady | output | 5 | Input buffer can take a flit |
| outValid | output | 5 | Flit valid per output port |
| outFlit | output | 5x34 | Flit per output port |
| outReady | input | 5 | Downstream can take a flit |

## Verification
Two things can happen to one output in the same cycle. A single-flit packet is granted and released at once. Separately, an end-of-packet release frees the output just as another header is waiting for it. The bench creates the first case by stalling the local output while four inputs each load a one-flit packet aimed at it, and then opening the output. The observed winner order must follow the rotating priority left by an earlier single grant. It creates the second case by starting a six-flit packet toward the local port and loading a competing header partway through. The competing header must not appear before the long packet's end flit, and it must appear exactly one cycle after that end flit is accepted.

// File: rtl/meshrt_pkg.sv
package meshrt_pkg;

  localparam int NPORT = 5;

  typedef logic [2:0] portIdx_t;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } portSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0]            popIn;
    logic [NPORT-1:0][2:0]       outSel;
  } ctlStrobe_t;

endpackage

// File: rtl/meshrt_datapath.sv
module meshrt_datapath
  import meshrt_pkg::*;
#(
  parameter int FLIT_W  = 34,
  parameter int COORD_W = 4,
  parameter int DEPTH   = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NPORT-1:0]                  inValid,
  input  logic [NPORT-1:0][FLIT_W-1:0]      inFlit,
  input  ctlStrobe_t                        ctl,
  output logic [NPORT-1:0]                  inReady,
  output logic [NPORT-1:0]                  headValid,
  output logic [NPORT-1:0]                  headBop,
  output logic [NPORT-1:0]                  headEop,
  output logic [NPORT-1:0][COORD_W-1:0]     headDX,
  output logic [NPORT-1:0][COORD_W-1:0]     headDY,
  output logic [NPORT-1:0][FLIT_W-1:0]      outFlit
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NPORT-1:0][FLIT_W-1:0] headFlit;

  for (genvar p = 0; p < NPORT; p++) begin : g_buf
    logic [FLIT_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wrP, rdP;
    logic [CW-1:0]     cnt;
    logic              full, push, pop;

    assign full       = (cnt == CW'(DEPTH));
    assign push       = inValid[p] && !full;
    assign pop        = ctl.popIn[p];
    assign inReady[p] = !full;

    always_ff @(posedge clk) begin
      if (push) mem[wrP] <= inFlit[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrP <= '0;
        rdP <= '0;
        cnt <= '0;
      end else begin
        if (push) wrP <= (wrP == AW'(DEPTH - 1)) ? '0 : wrP + 1'b1;
        if (pop)  rdP <= (rdP == AW'(DEPTH - 1)) ? '0 : rdP + 1'b1;
        case ({push, pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign headValid[p] = (cnt != '0);
    assign headFlit[p]  = mem[rdP];
    assign headBop[p]   = headFlit[p][FLIT_W-1];
    assign headEop[p]   = headFlit[p][FLIT_W-2];
    assign headDX[p]    = headFlit[p][2*COORD_W-1:COORD_W];
    assign headDY[p]    = headFlit[p][COORD_W-1:0];
  end

  // crossbar
  for (genvar o = 0; o < NPORT; o++) begin : g_xbar
    assign outFlit[o] = headFlit[ctl.outSel[o]];
  end

endmodule

// File: rtl/meshrt_control.sv
module meshrt_control
  import meshrt_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [COORD_W-1:0]            myX,
  input  logic [COORD_W-1:0]            myY,
  input  logic [NPORT-1:0]              headValid,
  input  logic [NPORT-1:0]              headBop,
  input  logic [NPORT-1:0]              headEop,
  input  logic [NPORT-1:0][COORD_W-1:0] headDX,
  input  logic [NPORT-1:0][COORD_W-1:0] headDY,
  input  logic [NPORT-1:0]              outReady,
  output logic [NPORT-1:0]              outValid,
  output ctlStrobe_t                    ctl
);

  function automatic portSel_t routeOf(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy,
                                       input logic [COORD_W-1:0] mx, input logic [COORD_W-1:0] my);
    if (dx > mx)      return PORT_EAST;
    else if (dx < mx) return PORT_WEST;
    else if (dy > my) return PORT_NORTH;
    else if (dy < my) return PORT_SOUTH;
    else              return PORT_LOCAL;
  endfunction

  function automatic int wrapIdx(input int a);
    return (a >= NPORT) ? a - NPORT : a;
  endfunction

  logic [NPORT-1:0] locked;
  portIdx_t         owner  [NPORT];
  portIdx_t         rrPtr  [NPORT];

  portSel_t         wantPort [NPORT];
  logic [NPORT-1:0] busy, wantNew, pickOk, xfer, selEop;
  portIdx_t         pick [NPORT];
  portIdx_t         sel  [NPORT];

  // request formation
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      busy[i] = 1'b0;
      for (int o = 0; o < NPORT; o++)
        if (locked[o] && owner[o] == portIdx_t'(i)) busy[i] = 1'b1;
      wantPort[i] = routeOf(headDX[i], headDY[i], myX, myY);
      wantNew[i]  = headValid[i] && headBop[i] && !busy[i];
    end
  end

  // rotating-priority pick per output
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      pickOk[o] = 1'b0;
      pick[o]   = '0;
      for (int k = 0; k < NPORT; k++) begin
        if (!pickOk[o] && wantNew[wrapIdx(int'(rrPtr[o]) + k)] &&
            wantPort[wrapIdx(int'(rrPtr[o]) + k)] == portSel_t'(o)) begin
          pickOk[o] = 1'b1;
          pick[o]   = portIdx_t'(wrapIdx(int'(rrPtr[o]) + k));
        end
      end
    end
  end

  // output select, handshake and pop strobes
  always_comb begin
    ctl = '0;
    for (int o = 0; o < NPORT; o++) begin
      sel[o]        = locked[o] ? owner[o] : pick[o];
      outValid[o]   = (locked[o] || pickOk[o]) && headValid[sel[o]];
      xfer[o]       = outValid[o] && outReady[o];
      selEop[o]     = headEop[sel[o]];
      ctl.outSel[o] = sel[o];
    end
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        if (xfer[o] && sel[o] == portIdx_t'(i)) ctl.popIn[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= '0;
      for (int o = 0; o < NPORT; o++) begin
        owner[o] <= '0;
        rrPtr[o] <= '0;
      end
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (!locked[o] && pickOk[o]) begin
          rrPtr[o] <= (pick[o] == portIdx_t'(NPORT - 1)) ? '0 : pick[o] + 1'b1;
          owner[o] <= pick[o];
          locked[o] <= !(xfer[o] && selEop[o]);
        end else if (locked[o] && xfer[o] && selEop[o]) begin
          locked[o] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import meshrt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int COORD_W   = 4,
  parameter int BUF_DEPTH = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [COORD_W-1:0]                myX,
  input  logic [COORD_W-1:0]                myY,
  input  logic [NPORT-1:0]                  inValid,
  input  logic [NPORT-1:0][DATA_W+1:0]      inFlit,
  output logic [NPORT-1:0]                  inReady,
  output logic [NPORT-1:0]                  outValid,
  output logic [NPORT-1:0][DATA_W+1:0]      outFlit,
  input  logic [NPORT-1:0]                  outReady
);

  localparam int FLIT_W = DATA_W + 2;

  ctlStrobe_t                   ctl;
  logic [NPORT-1:0]             headValid, headBop, headEop;
  logic [NPORT-1:0][COORD_W-1:0] headDX, headDY;

  meshrt_datapath #(.FLIT_W(FLIT_W), .COORD_W(COORD_W), .DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlit(inFlit), .ctl(ctl),
    .inReady(inReady), .headValid(headValid), .headBop(headBop), .headEop(headEop),
    .headDX(headDX), .headDY(headDY), .outFlit(outFlit)
  );

  meshrt_control #(.COORD_W(COORD_W)) u_ctl (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY), .headValid(headValid),
    .headBop(headBop), .headEop(headEop), .headDX(headDX), .headDY(headDY),
    .outReady(outReady), .outValid(outValid), .ctl(ctl)
  );

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
  import meshrt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [COORD_W-1:0]           myX,
  input logic [COORD_W-1:0]           myY,
  input logic [NPORT-1:0]             outValid,
  input logic [NPORT-1:0][DATA_W+1:0] outFlit,
  input logic [NPORT-1:0]             outReady
);

  localparam int BOP = DATA_W + 1;
  localparam int EOP = DATA_W;

  function automatic logic [COORD_W-1:0] colOf(input logic [DATA_W+1:0] f);
    return f[2*COORD_W-1:COORD_W];
  endfunction
  function automatic logic [COORD_W-1:0] rowOf(input logic [DATA_W+1:0] f);
    return f[COORD_W-1:0];
  endfunction

  // R2
  local_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[0] && outFlit[0][BOP] |-> colOf(outFlit[0]) == myX && rowOf(outFlit[0]) == myY);
  // R3
  east_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[3] && outFlit[3][BOP] |-> colOf(outFlit[3]) > myX);
  // R3
  west_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[4] && outFlit[4][BOP] |-> colOf(outFlit[4]) < myX);
  // R4
  north_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[1] && outFlit[1][BOP] |-> colOf(outFlit[1]) == myX && rowOf(outFlit[1]) > myY);
  // R4
  south_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[2] && outFlit[2][BOP] |-> colOf(outFlit[2]) == myX && rowOf(outFlit[2]) < myY);

  for (genvar o = 0; o < NPORT; o++) begin : g_port
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outFlit[o]));
    // R5
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && outReady[o] && !outFlit[o][EOP] |=> !(outValid[o] && outFlit[o][BOP]));
  end

endmodule

bind mesh_router mesh_router_chk #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .myX(myX), .myY(myY),
  .outValid(outValid), .outFlit(outFlit), .outReady(outReady)
);

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
  localparam int NP = 5;
  localparam int FW = 34;
  localparam int QD = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rstN;
  logic [3:0]           myX, myY;
  logic [NP-1:0]        inValid, inReady, outValid, outReady;
  logic [NP-1:0][FW-1:0] inFlit, outFlit;

  mesh_router u0 (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY), .inValid(inValid), .inFlit(inFlit),
    .inReady(inReady), .outValid(outValid), .outFlit(outFlit), .outReady(outReady)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [FW-1:0] qFlit [NP][QD];
  int            qPort [NP][QD];
  int            qWr[NP], qRd[NP], qExp[NP], seqCnt[NP];
  bit            presenting[NP], accPending[NP];
  int            bubblePct = 0, readyMode = 0;
  logic [NP-1:0] stallMask = '0;
  int            cyc = 0;
  bit            curAct[NP];
  int            curSrc[NP];
  bit            prevStall[NP];
  logic [FW-1:0] prevFlit[NP];
  bit            logOn = 0;
  int            logN = 0;
  int            logSrc[16], logCyc[16];
  int            eopCyc[NP];

  function automatic int expPort(int dx, int dy, int mx, int my);
    if (dx > mx) return 3;
    if (dx < mx) return 4;
    if (dy > my) return 1;
    if (dy < my) return 2;
    return 0;
  endfunction

  function automatic string reqOfPort(int p);
    if (p == 0) return "R2";
    if (p == 3 || p == 4) return "R3";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic addPacket(int src, int dx, int dy, int len);
    for (int k = 0; k < len; k++) begin
      logic [FW-1:0] f;
      f = '0;
      f[33] = (k == 0);
      f[32] = (k == len - 1);
      f[31:29] = 3'(src);
      f[27:12] = 16'(seqCnt[src]);
      seqCnt[src]++;
      if (k == 0) begin
        f[11:8] = 4'($urandom);
        f[7:4]  = 4'(dx);
        f[3:0]  = 4'(dy);
      end else begin
        f[11:0] = 12'($urandom);
      end
      if (qWr[src] < QD) begin
        qFlit[src][qWr[src]] = f;
        qPort[src][qWr[src]] = expPort(dx, dy, int'(myX), int'(myY));
        qWr[src]++;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < NP; i++) begin
      if (accPending[i]) begin
        qRd[i]++;
        presenting[i] = 0;
      end
      if (!presenting[i] && qRd[i] < qWr[i] && int'($urandom % 100) >= bubblePct)
        presenting[i] = 1;
      inValid[i] = presenting[i];
      inFlit[i]  = presenting[i] ? qFlit[i][qRd[i]] : '0;
    end
    for (int o = 0; o < NP; o++)
      outReady[o] = ((readyMode == 0) ? 1'b1 : ($urandom % 4 != 0)) && !stallMask[o];
    #1;
    for (int i = 0; i < NP; i++) accPending[i] = inValid[i] && inReady[i];
    for (int o = 0; o < NP; o++) begin
      if (prevStall[o])
        check(outValid[o] && outFlit[o] == prevFlit[o], "R8", "held flit changed",
              longint'(outFlit[o]), longint'(prevFlit[o]));
      prevStall[o] = outValid[o] && !outReady[o];
      prevFlit[o]  = outFlit[o];
      if (outValid[o] && outReady[o]) begin
        logic [FW-1:0] f;
        int s;
        f = outFlit[o];
        s = int'(f[31:29]);
        if (s >= NP || qExp[s] >= qWr[s]) begin
          check(0, "R1", "unexpected flit", longint'(f), 0);
        end else begin
          check(f == qFlit[s][qExp[s]], "R1", "flit content", longint'(f), longint'(qFlit[s][qExp[s]]));
          check(o == qPort[s][qExp[s]], reqOfPort(qPort[s][qExp[s]]), "output port", o, qPort[s][qExp[s]]);
          if (curAct[o]) check(s == curSrc[o], "R5", "interleaved source", s, curSrc[o]);
          else           check(f[33] == 1'b1, "R5", "packet start missing", f[33], 1);
          curAct[o] = !f[32];
          curSrc[o] = s;
          qExp[s]++;
          if (o == 0 && logOn) begin
            if (f[33] && logN < 16) begin
              logSrc[logN] = s;
              logCyc[logN] = cyc;
              logN++;
            end
            if (f[32]) eopCyc[s] = cyc;
          end
        end
      end
    end
  endtask

  task automatic waitDrain();
    bit done;
    done = 0;
    for (int n = 0; n < 3000 && !done; n++) begin
      step();
      done = 1;
      for (int i = 0; i < NP; i++)
        if (qExp[i] != qWr[i] || qRd[i] != qWr[i] || accPending[i]) done = 0;
    end
    check(done, "R5", "traffic drained", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) begin
      qWr[i] = 0; qRd[i] = 0; qExp[i] = 0; seqCnt[i] = 0;
      presenting[i] = 0; accPending[i] = 0; curAct[i] = 0; curSrc[i] = 0;
      prevStall[i] = 0; prevFlit[i] = '0; eopCyc[i] = 0;
    end
    rstN = 0; myX = 4'd1; myY = 4'd2;
    inValid = '0; inFlit = '0; outReady = '1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(outValid == '0, "R10", "outValid in reset", outValid, 0);
    check(inReady == '1, "R10", "inReady in reset", inReady, 5'h1f);
    rstN = 1;
    @(negedge clk);
    check(outValid == '0, "R10", "outValid after reset", outValid, 0);
    check(inReady == '1, "R10", "inReady after reset", inReady, 5'h1f);

    // R9: stalled output, input 4 takes exactly two flits
    stallMask = 5'b00001;
    addPacket(4, 1, 2, 4);
    repeat (6) step();
    check(qRd[4] + int'(accPending[4]) == 2, "R9", "flits accepted while stalled",
          qRd[4] + int'(accPending[4]), 2);
    check(inReady[4] == 1'b0, "R9", "ready while full", inReady[4], 0);
    check(outValid[0] && outFlit[0] == qFlit[4][0], "R8", "header held on stall",
          longint'(outFlit[0]), longint'(qFlit[4][0]));
    stallMask = '0;
    waitDrain();

    // R6: set priority past input 2, then four single-flit headers contend
    addPacket(2, 1, 2, 1);
    waitDrain();
    stallMask = 5'b00001;
    for (int s = 1; s < NP; s++) addPacket(s, 1, 2, 1);
    repeat (4) step();
    logOn = 1; logN = 0;
    stallMask = '0;
    waitDrain();
    check(logN == 4, "R6", "grant count", logN, 4);
    for (int k = 0; k < 4; k++)
      check(logSrc[k] == ((k + 2) % 4) + 1, "R6", "rotation order", logSrc[k], ((k + 2) % 4) + 1);

    // R7 and R11: held output resists higher-priority header, hand-over next cycle
    logN = 0;
    addPacket(1, 1, 2, 6);
    repeat (2) step();
    addPacket(3, 1, 2, 1);
    waitDrain();
    check(logN == 2 && logSrc[0] == 1, "R7", "held packet first", logSrc[0], 1);
    check(logSrc[1] == 3, "R7", "waiting header second", logSrc[1], 3);
    check(logCyc[1] == eopCyc[1] + 1, "R11", "hand-over cycle", logCyc[1], eopCyc[1] + 1);
    logOn = 0;

    // R2 R3 R4: each direction from several inputs
    addPacket(0, 1, 2, 2);
    addPacket(0, 2, 2, 1);
    addPacket(1, 0, 3, 3);
    addPacket(2, 1, 3, 1);
    addPacket(3, 1, 1, 2);
    addPacket(4, 3, 0, 1);
    waitDrain();

    // random phase, two router positions
    bubblePct = 30; readyMode = 1;
    for (int n = 0; n < 80; n++)
      addPacket(int'($urandom % NP), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4) + 1);
    waitDrain();
    myX = 4'd2; myY = 4'd1;
    for (int n = 0; n < 80; n++)
      addPacket(int'($urandom % NP), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4) + 1);
    waitDrain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule